// File: doc/BRIEF.md
# Oversampled Serial Receive Recovery

This block recovers characters from an asynchronous serial line. It samples the line only on cycles where a receiver-time tick enable is high. Sixteen such ticks make one bit time, and they are numbered RT1 to RT16. After the line has been idle and the search is enabled, a falling edge marks RT1 of a start bit. Three early samples confirm the start bit. Each data bit and the stop bit is then decided by a two-of-three vote around mid-bit.

At the end of each character the block emits a one-cycle full strobe together with the byte and two status flags. The noise flag reports any disagreement among samples. The framing flag reports a stop bit read as zero. Inside a character, falling edges near a bit boundary pull the tick phase back into line with the sender.

The state machine has five states:

- `ST_WAIT` counts idle high samples.
- `ST_HUNT` waits for the falling edge.
- `ST_START` runs start verification.
- `ST_DATA` collects the data bits.
- `ST_STOP` judges the stop bit.

Its transitions are:

- WAIT→HUNT: the idle run is reached and search is enabled.
- HUNT→WAIT: search is disabled.
- HUNT→START: a low sample arrives on a tick.
- START→WAIT: the start bit is rejected at RT7.
- START→DATA: RT16 of the start bit.
- DATA→STOP: RT16 of the last data bit.
- STOP→WAIT: RT10 of the stop bit.

Top module: `srx_top`

## Requirements
- R1: While reset is low, `rx_full`, `noise_flag`, `frame_err` and `rx_data` are all 0.
- R2: A start bit is recognised only while `search_en` is 1. The line must first have been high on at least 3 consecutive ticks; the first tick that samples 0 after that becomes RT1.
- R3: The start bit is sampled at RT3, RT5 and RT7. If two or more of those samples are 1, no character is delivered and the search for a new start bit begins again.
- R4: If exactly one of the RT3/RT5/RT7 samples is 1, the start bit is still accepted, and the delivered character carries `noise_flag` = 1.
- R5: After the start bit is accepted, a 1 in any of its RT8, RT9 or RT10 samples sets `noise_flag` for that character, and reception continues.
- R6: There are 8 data bits, received least-significant first. Each bit is the majority of its RT8, RT9 and RT10 samples, and any disagreement among those three samples sets `noise_flag`.
- R7: The stop bit is the majority of its RT8/RT9/RT10 samples. A majority of 0 sets `frame_err`, including for an all-zero break, and any disagreement sets `noise_flag`.
- R8: `rx_full` is high for exactly one clock per character, in the clock after the stop bit's RT10 tick. `rx_data`, `noise_flag` and `frame_err` take their new values on that same edge.
- R9: `noise_flag`, `frame_err` and `rx_data` hold their values until the next character completes. A 1 on `flag_clr` clears both flags on the next edge; if a character completes on that edge, the completion wins.
- R10: During data and stop bits, a 1-to-0 change between consecutive ticks resynchronises the phase when it lands on RT2, RT3 or RT4. That tick is taken as RT1.
- R11: Line values present on cycles where `rt_tick` is 0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rt_tick | input | 1 | Sample enable, 16 per bit time |
| rxd | input | 1 | Serial line, already synchronised |
| search_en | input | 1 | Allows a new start-bit search |
| flag_clr | input | 1 | Synchronous clear of the noise and framing flags |
| rx_data | output | DATA_BITS | Last received character |
| rx_full | output | 1 | One-cycle strobe when a character completes |
| noise_flag | output | 1 | Sample disagreement seen in the last character |
| frame_err | output | 1 | Stop bit read as 0 in the last character |

## Verification
The bench plants single-sample glitches at RT5 and RT9 of the start bit, and at RT9 of a data bit and of the stop bit. A design that ignored them would miss `noise_flag`; a design with a wrong vote would corrupt the byte. A rejected start pulse, a break, a stop bit with two low samples and a frame sent while search is disabled check that bad or unwanted frames give no strobe, or the correct framing error. A sender that stretches every bit to 17 ticks sends 0x55; if resynchronisation were missing, the stop samples would drift into the last data bit and raise a false framing error. Opposite line values placed on the cycles between ticks expose any logic that samples off the enable.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } srx_state_e;
endpackage

// File: rtl/srx_vote3.sv
// Two-of-three vote over the held samples plus the current one.
module srx_vote3 (
    input  logic [2:0] smp,
    output logic       maj,
    output logic       mixed,
    output logic       any1
);
    assign maj   = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
    assign any1  = |smp;
    assign mixed = any1 & ~(&smp);
endmodule

// File: rtl/srx_idle_cnt.sv
// Counts consecutive high samples, saturating at RUN.
module srx_idle_cnt #(
    parameter int RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic clr,
    output logic ok
);
    localparam int W = $clog2(RUN + 1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (tick) begin
            if (!line)                 cnt_q <= '0;
            else if (cnt_q != W'(RUN)) cnt_q <= cnt_q + W'(1);
        end
    end

    assign ok = (cnt_q == W'(RUN));
endmodule

// File: rtl/srx_shreg.sv
// Right shift register: first bit in ends at bit 0.
module srx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    generate
        if (W == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= {din, q[W-1:1]};
            end
        end
    endgenerate
endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16,
    parameter int IDLE_RUN   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rt_tick,
    input  logic                 rxd,
    input  logic                 search_en,
    input  logic                 flag_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 noise_flag,
    output logic                 frame_err
);
    localparam int PW = $clog2(OVERSAMPLE) + 1;
    localparam int CW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [PW-1:0] P_ONE    = PW'(1);
    localparam logic [PW-1:0] P_CHK_A  = PW'(3 * OVERSAMPLE / 16);
    localparam logic [PW-1:0] P_CHK_B  = PW'(5 * OVERSAMPLE / 16);
    localparam logic [PW-1:0] P_CHK_C  = PW'(7 * OVERSAMPLE / 16);
    localparam logic [PW-1:0] P_MID_A  = PW'(OVERSAMPLE / 2);
    localparam logic [PW-1:0] P_MID_B  = PW'(OVERSAMPLE / 2 + 1);
    localparam logic [PW-1:0] P_MID_C  = PW'(OVERSAMPLE / 2 + 2);
    localparam logic [PW-1:0] P_RS_MAX = PW'(OVERSAMPLE / 4);
    localparam logic [PW-1:0] P_LAST   = PW'(OVERSAMPLE);
    localparam logic [CW-1:0] LAST_BIT = CW'(DATA_BITS - 1);

    srx_state_e state_q, state_d;
    logic [PW-1:0] phase_q, pos_raw, pos;
    logic [CW-1:0] bit_q;
    logic          prev_q, s_a_q, s_b_q, noise_acc_q;
    logic          in_frame, busy, resync, idle_ok;
    logic          v_maj, v_mixed, v_any1;
    logic          shift_en, done;
    logic [DATA_BITS-1:0] sh_q;

    assign in_frame = (state_q == ST_DATA) || (state_q == ST_STOP);
    assign busy     = in_frame || (state_q == ST_START);

    srx_idle_cnt #(.RUN(IDLE_RUN)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(rt_tick), .line(rxd),
        .clr(busy), .ok(idle_ok)
    );

    srx_vote3 u_vote (
        .smp({s_a_q, s_b_q, rxd}), .maj(v_maj), .mixed(v_mixed), .any1(v_any1)
    );

    // Phase of the current tick, with re-alignment on late falling edges.
    always_comb begin
        pos_raw = (phase_q == P_LAST) ? P_ONE : phase_q + P_ONE;
        resync  = in_frame && prev_q && !rxd
                  && (pos_raw >= PW'(2)) && (pos_raw <= P_RS_MAX);
        pos     = resync ? P_ONE : pos_raw;
    end

    assign shift_en = rt_tick && (state_q == ST_DATA) && (pos == P_MID_C);
    assign done     = rt_tick && (state_q == ST_STOP) && (pos == P_MID_C);

    srx_shreg #(.W(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift(shift_en), .din(v_maj), .q(sh_q)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (idle_ok && search_en) state_d = ST_HUNT;
            ST_HUNT: begin
                if (!search_en)            state_d = ST_WAIT;
                else if (rt_tick && !rxd)  state_d = ST_START;
            end
            ST_START: if (rt_tick) begin
                if (pos == P_CHK_C && v_maj) state_d = ST_WAIT;
                else if (pos == P_LAST)      state_d = ST_DATA;
            end
            ST_DATA:  if (rt_tick && pos == P_LAST && bit_q == LAST_BIT) state_d = ST_STOP;
            ST_STOP:  if (done) state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Sample and phase datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= '0;
            prev_q      <= 1'b1;
            s_a_q       <= 1'b0;
            s_b_q       <= 1'b0;
            bit_q       <= '0;
            noise_acc_q <= 1'b0;
        end else if (rt_tick) begin
            prev_q <= rxd;
            if (state_q == ST_HUNT && search_en && !rxd) begin
                phase_q     <= P_ONE;
                bit_q       <= '0;
                noise_acc_q <= 1'b0;
            end else if (busy) begin
                phase_q <= pos;
                if (pos == P_CHK_A || pos == P_MID_A) s_a_q <= rxd;
                if (pos == P_CHK_B || pos == P_MID_B) s_b_q <= rxd;
                if (state_q == ST_START && pos == P_CHK_C) noise_acc_q <= noise_acc_q | v_mixed;
                if (state_q == ST_START && pos == P_MID_C) noise_acc_q <= noise_acc_q | v_any1;
                if (state_q == ST_DATA  && pos == P_MID_C) noise_acc_q <= noise_acc_q | v_mixed;
                if (state_q == ST_DATA  && pos == P_LAST)  bit_q <= bit_q + CW'(1);
            end
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full    <= 1'b0;
            rx_data    <= '0;
            noise_flag <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_full <= 1'b0;
            if (done) begin
                rx_full    <= 1'b1;
                rx_data    <= sh_q;
                noise_flag <= noise_acc_q | v_mixed;
                frame_err  <= !v_maj;
            end else if (flag_clr) begin
                noise_flag <= 1'b0;
                frame_err  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rt_tick,
    input logic          rxd,
    input logic          search_en,
    input logic          flag_clr,
    input logic          rx_full,
    input logic          noise_flag,
    input logic          frame_err,
    input logic [DW-1:0] rx_data,
    input logic          st_start,
    input logic          idle_ok
);
    assert_strobe_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> !rx_full);

    assert_strobe_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> $past(rt_tick));

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr ##1 !rx_full |-> !noise_flag && !frame_err);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr ##1 !rx_full |-> $stable(noise_flag) && $stable(frame_err) && $stable(rx_data));

    assert_hunt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_start) |-> $past(idle_ok && search_en && rt_tick && !rxd));
endmodule

bind srx_top srx_checker #(.DW(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd(rxd),
    .search_en(search_en), .flag_clr(flag_clr), .rx_full(rx_full),
    .noise_flag(noise_flag), .frame_err(frame_err), .rx_data(rx_data),
    .st_start(state_q == ST_START), .idle_ok(idle_ok)
);

// File: tb/sim_srx_top.sv
module sim_srx_top;
    logic clk = 0, rst_n = 0, rt_tick = 0, rxd = 1, search_en = 0, flag_clr = 0;
    logic [7:0] rx_data;
    logic rx_full, noise_flag, frame_err;
    int n_chk = 0, n_fail = 0, n_full = 0, base = 0;
    bit fin = 0;
    logic full_d = 0;

    typedef struct { logic [7:0] d; logic n; logic f; string tag; } exp_t;
    exp_t exp_q[$];
    exp_t e;

    always #2 clk = ~clk;

    srx_top u0 (
        .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd(rxd),
        .search_en(search_en), .flag_clr(flag_clr), .rx_data(rx_data),
        .rx_full(rx_full), .noise_flag(noise_flag), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input logic v, input bit jit = 0);
        @(negedge clk); rxd = v; rt_tick = 1;
        @(negedge clk); rt_tick = 0;
        if (jit) rxd = !v;
    endtask

    task automatic expect_char(input logic [7:0] d, input logic n, input logic f, input string tag);
        exp_q.push_back('{d, n, f, tag});
    endtask

    // Frame: start, 8 data LSB first, stop. Indices g1/g2 flip one tick each.
    task automatic send(input logic [7:0] d, input int g1 = -1, input int g2 = -1,
                        input int blen = 16, input logic stop_v = 1,
                        input bit brk = 0, input bit jit = 0);
        int idx = 0;
        repeat (5) tick(1);
        for (int b = 0; b < 10; b++) begin
            logic v;
            v = (b == 0 || brk) ? 1'b0 : (b < 9) ? d[b-1] : stop_v;
            for (int k = 0; k < blen; k++) begin
                tick((idx == g1 || idx == g2) ? !v : v, jit);
                idx++;
            end
        end
        repeat (4) tick(1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_full) begin
            n_full++;
            if (exp_q.size() == 0) check(0, "R8", "unexpected rx_full", 1, 0);
            else begin
                e = exp_q.pop_front();
                check(rx_data == e.d, e.tag, "data", rx_data, e.d);
                check(noise_flag == e.n, e.tag, "noise_flag", noise_flag, e.n);
                check(frame_err == e.f, e.tag, "frame_err", frame_err, e.f);
            end
            if (full_d) check(0, "R8", "strobe wider than one cycle", 1, 0);
        end
        full_d <= rx_full;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(rx_full == 0 && noise_flag == 0 && frame_err == 0 && rx_data == 0,
              "R1", "reset outputs", {rx_data, rx_full, noise_flag, frame_err}, 0);
        rst_n = 1; search_en = 1;

        expect_char(8'hA5, 0, 0, "R6"); send(8'hA5);                          // R6 clean
        expect_char(8'h3C, 0, 0, "R11"); send(8'h3C, -1, -1, 16, 1, 0, 1);  // R11 off-tick noise
        expect_char(8'h96, 1, 0, "R4"); send(8'h96, 4);                       // R4 RT5 glitch

        // R3 rejected start: RT3 and RT5 high
        base = n_full;
        repeat (5) tick(1);
        tick(0); tick(0); tick(1); tick(0); tick(1); tick(0); tick(0);
        repeat (6) tick(1);
        check(n_full == base, "R3", "rx_full count after rejected start", n_full - base, 0);

        expect_char(8'h0F, 1, 0, "R5"); send(8'h0F, 8);                       // R5 start RT9
        expect_char(8'hA5, 1, 0, "R6"); send(8'hA5, 56);                      // R6 data RT9
        expect_char(8'h04, 1, 0, "R6"); send(8'h00, 55, 56);                  // R6 majority flip
        expect_char(8'h5A, 1, 0, "R7"); send(8'h5A, 152);                     // R7 stop noise
        expect_char(8'hC3, 1, 1, "R7"); send(8'hC3, 151, 152);                // R7 stop low

        // R9 hold then clear
        repeat (10) tick(1);
        check(noise_flag && frame_err && rx_data == 8'hC3, "R9", "flags held",
              {rx_data, noise_flag, frame_err}, {8'hC3, 2'b11});
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        check(!noise_flag && !frame_err, "R9", "flags after clear", {noise_flag, frame_err}, 0);

        expect_char(8'h00, 0, 1, "R7"); send(8'h00, -1, -1, 16, 1, 1);       // R7 break

        // R2 search disabled
        search_en = 0; base = n_full;
        send(8'h11);
        check(n_full == base, "R2", "rx_full with search disabled", n_full - base, 0);
        search_en = 1;
        expect_char(8'h11, 0, 0, "R2"); send(8'h11);

        expect_char(8'h55, 0, 0, "R10"); send(8'h55, -1, -1, 17);            // R10 slow sender

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8", "characters never delivered", exp_q.size(), 0);
        fin = 1;
        summary();
        $finish;
    end
endmodule